// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between the access logic of an SDRAM controller and the memory command pins. Software supplies a two-bit low-power selection and a two-bit idle timeout. When the selection asks for power-down, the block counts the idle cycles after the last access. Once the timeout is met, it closes the open banks with a precharge and waits a programmable row-precharge time while driving only NOPs. It then drops the clock enable and holds it low while the clock keeps running. A new access request raises the clock enable again, and the access is held back for a programmable exit delay.

When the selection asks for deep power-down, the block does not wait for any idle time. It ends a read that is in progress with a burst-terminate command, then precharges, then waits the row-precharge time. It then issues the deep power-down command with the clock enable low and freezes. In the frozen state no access is granted. The block leaves that state only after software writes the selection back to zero, which makes the block pulse a re-initialization request, and the external initialization logic then reports completion.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset, cke is 1, cmd is PASS (0), grant is 1, frozen is 0 and reinit_req is 0.
- R2: With lp_sel = 01 and lp_tmo = 00 or 11, cmd is PRE (2) after the first rising edge that follows the edge sampling acc_done with acc_req low.
- R3: With lp_sel = 01, lp_tmo = 01 gives PRE after the 65th rising edge following the acc_done edge, and lp_tmo = 10 gives PRE after the 129th, provided the memory stays idle.
- R4: Power-down entry drives PRE for one cycle, then NOP (1) with cke high for max(1, trp_cyc) cycles, then NOP with cke low. cke stays low while idle.
- R5: A request on acc_req in power-down raises cke after the next edge. grant then stays low with cmd NOP for max(1, exit_cyc) cycles, after which grant is 1 and cmd is PASS.
- R6: The idle count restarts on every acc_req or acc_done cycle and on every change of lp_sel. The timeout is measured from the edge that samples the new lp_sel value.
- R7: lp_sel = 11 with rd_active high drives BST (3), PRE, NOP with cke high for max(1, trp_cyc) cycles, and then DPD (4) with cke low. After that, frozen is 1, cke is 0 and cmd is NOP.
- R8: lp_sel = 11 with rd_active low starts the same sequence at PRE, without any BST.
- R9: While frozen, acc_req and every lp_sel value other than 00 have no effect: frozen stays 1, grant 0, cke 0 and reinit_req 0.
- R10: Writing lp_sel = 00 while frozen raises reinit_req for exactly one cycle. The block then drives cke 1 and cmd PASS with frozen still 1 and grant 0. On the edge that samples reinit_done, it sets frozen to 0 and grant to 1.
- R11: lp_sel values 00 and 10 never lower cke or grant, however long the memory stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_sel | input | 2 | Low-power selection: 01 power-down, 11 deep power-down, others none |
| lp_tmo | input | 2 | Idle timeout: 00/11 immediate, 01 64 cycles, 10 128 cycles |
| trp_cyc | input | DLY_W | Row-precharge wait in cycles (0 acts as 1) |
| exit_cyc | input | DLY_W | Power-down exit delay in cycles (0 acts as 1) |
| acc_req | input | 1 | Access request from the access logic |
| acc_done | input | 1 | One-cycle pulse when an access completes |
| rd_active | input | 1 | A read burst is in progress |
| reinit_done | input | 1 | Initialization sequence finished |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 3 | Command select: 0 PASS, 1 NOP, 2 PRE, 3 BST, 4 DPD |
| grant | output | 1 | Access logic may drive the pins |
| frozen | output | 1 | Deep power-down / re-initialization pending |
| reinit_req | output | 1 | One-cycle re-initialization request |

## Verification
Every output comes from one state register, so a result is due on the rising edge after the stimulus that is sampled. The one exception is reinit_req, which follows lp_sel within the same cycle. The bench drives inputs and samples outputs 2 ns after each rising edge. It counts the edges from the acc_done edge, or from the lp_sel-change edge, until PRE appears, and compares that count with the timeout plus one. It then counts the NOP cycles against max(1, trp_cyc) or max(1, exit_cyc) before it checks cke or grant. reinit_req is checked 1 ns after lp_sel changes, before the next edge.

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq #(
  parameter int CNT_W = 8,
  parameter int DLY_W = 4,
  parameter int TMO_A = 64,
  parameter int TMO_B = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lp_sel,
  input  logic [1:0]       lp_tmo,
  input  logic [DLY_W-1:0] trp_cyc,
  input  logic [DLY_W-1:0] exit_cyc,
  input  logic             acc_req,
  input  logic             acc_done,
  input  logic             rd_active,
  input  logic             reinit_done,
  output logic             cke,
  output logic [2:0]       cmd,
  output logic             grant,
  output logic             frozen,
  output logic             reinit_req
);
  localparam logic [2:0] C_PASS = 3'd0, C_NOP = 3'd1, C_PRE = 3'd2, C_BST = 3'd3, C_DPD = 3'd4;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  typedef enum logic [3:0] {S_NORM, S_BST, S_PRE, S_TRP, S_PD, S_XIT, S_DPD, S_FRZ, S_RQW} st_t;
  st_t st, st_n;
  logic             deep_q, deep_n;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] idle_q, limit;
  logic [DLY_W-1:0] dcnt_q;
  logic             pd_ok;

  always_comb
    case (lp_tmo)
      2'b01:   limit = CNT_W'(TMO_A);
      2'b10:   limit = CNT_W'(TMO_B);
      default: limit = '0;
    endcase

  assign pd_ok = (lp_sel == 2'b01) && (sel_q == lp_sel) && !acc_req && !acc_done && (idle_q >= limit);

  always_comb begin
    st_n   = st;
    deep_n = deep_q;
    case (st)
      S_NORM: if (lp_sel == 2'b11) begin
                st_n = rd_active ? S_BST : S_PRE; deep_n = 1'b1;
              end else if (pd_ok) begin
                st_n = S_PRE; deep_n = 1'b0;
              end
      S_BST:  st_n = S_PRE;
      S_PRE:  st_n = S_TRP;
      S_TRP:  if (dcnt_q <= 1) st_n = deep_q ? S_DPD : S_PD;
      S_PD:   if (acc_req || lp_sel != 2'b01) st_n = S_XIT;
      S_XIT:  if (dcnt_q <= 1) st_n = S_NORM;
      S_DPD:  st_n = S_FRZ;
      S_FRZ:  if (lp_sel == 2'b00) st_n = S_RQW;
      S_RQW:  if (reinit_done) st_n = S_NORM;
      default: st_n = S_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_NORM; deep_q <= 1'b0; sel_q <= 2'b00; idle_q <= '0; dcnt_q <= '0;
    end else begin
      st     <= st_n;
      deep_q <= deep_n;
      sel_q  <= lp_sel;
      if (acc_req || acc_done || lp_sel != sel_q || st != S_NORM) idle_q <= '0;
      else if (idle_q != CMAX) idle_q <= idle_q + 1'b1;
      if (st == S_PRE) dcnt_q <= trp_cyc;
      else if (st == S_PD) dcnt_q <= exit_cyc;
      else if (dcnt_q != 0) dcnt_q <= dcnt_q - 1'b1;
    end

  assign cke        = !(st == S_PD || st == S_DPD || st == S_FRZ);
  assign grant      = (st == S_NORM);
  assign frozen     = (st == S_DPD || st == S_FRZ || st == S_RQW);
  assign reinit_req = (st == S_FRZ) && (lp_sel == 2'b00);

  always_comb
    case (st)
      S_NORM, S_RQW: cmd = C_PASS;
      S_BST:         cmd = C_BST;
      S_PRE:         cmd = C_PRE;
      S_DPD:         cmd = C_DPD;
      default:       cmd = C_NOP;
    endcase

  assert_grant_cke_R1: assert property (@(posedge clk) disable iff (!rst_n) grant |-> cke);
  assert_pre_nop_R4: assert property (@(posedge clk) disable iff (!rst_n) (cmd == C_PRE) |=> (cmd == C_NOP && cke));
  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n) (!cke && !frozen && acc_req) |=> cke);
  assert_bst_pre_R7: assert property (@(posedge clk) disable iff (!rst_n) (cmd == C_BST) |=> (cmd == C_PRE));
  assert_dpd_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n) (cmd == C_DPD) |=> (frozen && !cke));
  assert_frozen_hold_R9: assert property (@(posedge clk) disable iff (!rst_n) (frozen && !reinit_done) |=> frozen);
  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n) reinit_req |=> !reinit_req);
endmodule

// File: tb/sdram_lp_seq_tb.sv
module sdram_lp_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic [1:0] lp_sel = 0, lp_tmo = 0;
  logic [3:0] trp_cyc = 0, exit_cyc = 0;
  logic acc_req = 0, acc_done = 0, rd_active = 0, reinit_done = 0;
  logic cke, grant, frozen, reinit_req;
  logic [2:0] cmd;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sdram_lp_seq dut_i (.clk, .rst_n, .lp_sel, .lp_tmo, .trp_cyc, .exit_cyc, .acc_req, .acc_done,
    .rd_active, .reinit_done, .cke, .cmd, .grant, .frozen, .reinit_req);

  // tmo, trp, PRE edge count
  localparam int VT [4][3] = '{'{0, 3, 1}, '{1, 0, 65}, '{2, 5, 129}, '{3, 2, 1}};

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic do_reset;
    rst_n = 0; lp_sel = 0; acc_req = 0; acc_done = 0; rd_active = 0; reinit_done = 0;
    tick; tick; rst_n = 1; tick;
  endtask

  task automatic count_to_pre(output int k);
    k = 0;
    do begin tick; k++; end while (cmd != 3'd2 && k < 400);
  endtask

  task automatic count_nops(output int n);
    n = 0;
    tick;
    while (cmd == 3'd1 && cke && n < 40) begin n++; tick; end
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, n;
    do_reset;
    chk("R1 cke", cke, 1); chk("R1 cmd", cmd, 0); chk("R1 grant", grant, 1);
    chk("R1 frozen", frozen, 0); chk("R1 reinit_req", reinit_req, 0);

    foreach (VT[i]) begin
      do_reset;
      lp_tmo = VT[i][0]; trp_cyc = VT[i][1];
      acc_req = 1; lp_sel = 2'b01; tick; tick;
      acc_req = 0; acc_done = 1; tick; acc_done = 0;
      count_to_pre(k);
      chk(VT[i][2] == 1 ? "R2 pre edges" : "R3 pre edges", k, VT[i][2]);
      count_nops(n);
      chk("R4 nop count", n, VT[i][1] == 0 ? 1 : VT[i][1]);
      chk("R4 cke low", cke, 0); chk("R4 cmd nop", cmd, 1);
      repeat (10) tick;
      chk("R4 cke held", cke, 0);
    end

    // R5 wake with exit delay 3
    exit_cyc = 3; acc_req = 1; tick;
    chk("R5 cke up", cke, 1); chk("R5 grant low", grant, 0);
    n = 0;
    while (!grant && n < 20) begin chk("R5 nop", cmd, 1); n++; tick; end
    chk("R5 exit cycles", n, 3); chk("R5 pass", cmd, 0);

    // R6 restart on access, lp_tmo=01
    do_reset; lp_tmo = 1; lp_sel = 2'b01; acc_req = 1; tick;
    acc_req = 0; acc_done = 1; tick; acc_done = 0;
    repeat (40) tick;
    acc_done = 1; tick; acc_done = 0;
    count_to_pre(k); chk("R6 restart on done", k, 65);
    // R6 restart on lp_sel change
    do_reset; lp_tmo = 1; lp_sel = 2'b10; repeat (100) tick;
    lp_sel = 2'b01; tick;
    count_to_pre(k); chk("R6 restart on sel change", k, 65);

    // R11 no power-down for 00 and 10
    do_reset; lp_tmo = 0; lp_sel = 2'b10; n = 0;
    repeat (200) begin tick; if (!cke || !grant) n++; end
    lp_sel = 2'b00;
    repeat (200) begin tick; if (!cke || !grant) n++; end
    chk("R11 never low", n, 0);

    // R7 deep with read
    do_reset; trp_cyc = 2; rd_active = 1; lp_sel = 2'b11; tick;
    chk("R7 bst", cmd, 3); tick; chk("R7 pre", cmd, 2);
    count_nops(n); chk("R7 nop count", n, 2);
    chk("R7 dpd", cmd, 4); chk("R7 dpd cke", cke, 0);
    tick; chk("R7 frozen", frozen, 1); chk("R7 cke", cke, 0); chk("R7 nop", cmd, 1);

    // R9 frozen ignores
    rd_active = 0; acc_req = 1; lp_sel = 2'b01; repeat (5) tick;
    lp_sel = 2'b10; acc_req = 0; repeat (5) tick;
    chk("R9 frozen", frozen, 1); chk("R9 grant", grant, 0);
    chk("R9 cke", cke, 0); chk("R9 reinit_req", reinit_req, 0);

    // R10 reinit handshake
    lp_sel = 2'b00; #1;
    chk("R10 req high", reinit_req, 1);
    tick;
    chk("R10 req pulse", reinit_req, 0); chk("R10 cke", cke, 1); chk("R10 cmd", cmd, 0);
    repeat (4) tick;
    chk("R10 still frozen", frozen, 1); chk("R10 grant low", grant, 0);
    reinit_done = 1; tick; reinit_done = 0;
    chk("R10 unfrozen", frozen, 0); chk("R10 grant", grant, 1);

    // R8 deep without read, trp 0
    do_reset; trp_cyc = 0; lp_sel = 2'b11; tick;
    chk("R8 pre first", cmd, 2);
    count_nops(n); chk("R8 nop count", n, 1);
    chk("R8 dpd", cmd, 4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule